// File: doc/BRIEF.md
# Configurable UART Line Receiver

This block turns a serial line into bytes. It watches one of two pins, chosen by a swap setting, and brings the level into the clock domain through a two-stage synchronizer. Before anything else looks at the level, it can be complemented to allow for an external inverter on the pin. A 16x oversampling tick paces all timing. Each bit slot is sixteen ticks long, and the receiver takes the majority of three samples near the middle of each slot. A byte comes out with a one-cycle valid strobe. Parity and framing error flags are raised in the same cycle as that strobe.

The configuration covers pin inversion, logical data inversion (which also covers the parity bit), pin swap, parity enable with even or odd sense, stop length, and a bus-break mode. In that mode, a line held low for eleven or more bit times is reported as a break and no byte is delivered for that frame. The configuration is captured only while the block is disabled. It stays frozen while the block is enabled, so software may change the configuration inputs only during the disabled window.

Top module: `uart_line_rx`

## Requirements
- R1: While `enable` is low the receiver delivers nothing: `rx_valid`, `parity_err`, `frame_err` and `break_det` stay low. All four are low after reset.
- R2: A frame is a start slot, eight data slots sent least significant bit first, an optional parity slot, and the stop time, each slot 16 ticks. Counting the tick that first sees the line low as tick 1, `rx_valid` pulses for one cycle after tick 16+128+16·P+S. P is 1 with parity on. S is the stop length in ticks.
- R3: A start is confirmed only if the line is still low at the ninth tick of the start slot (8 ticks after the first low tick). Otherwise the receiver returns to idle and delivers nothing.
- R4: Each slot's value is the majority of its samples at tick positions 7, 8 and 9, counted from 0. A single differing sample among them does not change the bit.
- R5: With `cfg_pin_inv`=1 the pin level is complemented before synchronizing, so the idle level on the pin is low.
- R6: With `cfg_data_inv`=1 the data bits and the parity bit are complemented after sampling, and parity is checked on the complemented values.
- R7: With `cfg_swap`=1 the receiver listens on `tx_pin` and ignores `rx_pin`. With `cfg_swap`=0 it listens on `rx_pin` and ignores `tx_pin`.
- R8: With `cfg_par_en`=1, the parity bit is expected to equal the XOR of the data bits for `cfg_par_odd`=0, or its complement for `cfg_par_odd`=1. A mismatch raises `parity_err` together with `rx_valid`.
- R9: `cfg_stop_sel` sets the stop length: 2'b00 is 1 bit (16 ticks), 2'b01 is 0.5 bit (8 ticks), 2'b10 is 2 bits (32 ticks) and 2'b11 is 1.5 bits (24 ticks).
- R10: The first stop bit is sampled at majority positions 7, 8 and 9 (3, 4 and 5 for the half-bit setting). A low result raises `frame_err` with `rx_valid`, and the receiver then waits for the line to go high before it looks for a new start.
- R11: With `cfg_lin_en`=1, a line held low for 176 consecutive ticks (11 bit times) raises `break_det` for one cycle after the 176th low tick, once per low stretch. A frame whose sampled bits are all low and whose stop sample is low is not delivered. A stretch of 175 low ticks raises no break.
- R12: With `cfg_lin_en`=0, `break_det` never rises, and a long low stretch is delivered as byte 0x00 with `frame_err`.
- R13: Changes on the configuration inputs while `enable` is high have no effect until `enable` has been low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Receiver on; configuration captured while low |
| os_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_pin | input | 1 | Normal receive pin |
| tx_pin | input | 1 | Normal transmit pin, used for receive when swapped |
| cfg_pin_inv | input | 1 | Complement the pin level |
| cfg_data_inv | input | 1 | Complement data and parity bits |
| cfg_swap | input | 1 | Take the line from `tx_pin` |
| cfg_lin_en | input | 1 | Enable long-break detection |
| cfg_par_en | input | 1 | Expect a parity slot |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_stop_sel | input | 2 | Stop length code |
| rx_data | output | 8 | Received byte, valid with `rx_valid` |
| rx_valid | output | 1 | One-cycle strobe per delivered frame |
| parity_err | output | 1 | Parity mismatch, only with `rx_valid` |
| frame_err | output | 1 | Low stop sample, only with `rx_valid` |
| break_det | output | 1 | One-cycle pulse on a long low stretch |

## Verification
The bench places a false start that recovers before the mid-start sample, and a design that confirms too early would deliver a phantom byte. It flips one of the three middle samples in every data slot, which would corrupt bytes in a design that samples a single point or uses the wrong window. It times the strobe for every stop code and measures low stretches of exactly 175 and 176 ticks in break mode, so that an off-by-one limit, a swapped stop encoding or a delivered break frame shows up as a wrong tick count or a stray strobe. It also drives noise on the unused pin and changes the configuration inputs while enabled, so a receiver that ignored swap or the enable freeze would decode garbage.

// File: rtl/uart_rx_pkg.sv
// Package: shared types and helpers for the configurable line receiver.
// Assumes a single clock domain; the line input is already synchronized
// by the time any function here is applied.
package uart_rx_pkg;

    // Captured configuration word, held stable while the receiver runs.
    typedef struct packed {
        logic       pin_inv;
        logic       data_inv;
        logic       swap;
        logic       lin_en;
        logic       par_en;
        logic       par_odd;
        logic [1:0] stop_sel;
    } rx_cfg_t;

    // Stop length codes; the decoding is fixed behaviour.
    localparam logic [1:0] STOP_ONE      = 2'b00;
    localparam logic [1:0] STOP_HALF     = 2'b01;
    localparam logic [1:0] STOP_TWO      = 2'b10;
    localparam logic [1:0] STOP_ONE_HALF = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_HOLD
    } rx_state_t;

    // Two-of-three vote over the mid-slot samples.
    function automatic logic maj3(input logic [2:0] v);
        return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
    endfunction

endpackage

// File: rtl/uart_rx_cfg_hold.sv
// Configuration holder: follows the configuration inputs while the
// receiver is disabled and freezes them while it is enabled.
// Assumes software only changes the inputs in the disabled window.
module uart_rx_cfg_hold
    import uart_rx_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    enable,
    input  rx_cfg_t cfg_in,
    output rx_cfg_t cfg_q
);

    // Capture the configuration only while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (!enable) begin
            cfg_q <= cfg_in;
        end
    end

endmodule

// File: rtl/uart_rx_front.sv
// Line front end: selects the pin (normal or swapped), applies the
// optional pin inversion, then synchronizes through SYNC_STAGES flops.
// Assumes SYNC_STAGES >= 2; the output resets to the idle (high) level.
module uart_rx_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_pin,
    input  logic tx_pin,
    input  logic swap,
    input  logic pin_inv,
    output logic line
);

    logic                   raw_lvl;
    logic [SYNC_STAGES-1:0] sync_q;

    // Pick the pin and undo an external inverter before anything else.
    always_comb begin
        raw_lvl = (swap ? tx_pin : rx_pin) ^ pin_inv;
    end

    // Metastability chain; reset to logical idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw_lvl};
        end
    end

    assign line = sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/uart_rx_brk.sv
// Long-break detector: counts consecutive low oversampling ticks and
// pulses once when the count reaches BREAK_BITS bit times.
// Assumes the line input is synchronized; inactive unless lin_en is set.
module uart_rx_brk #(
    parameter int OS         = 16,
    parameter int BREAK_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic lin_en,
    input  logic tick,
    input  logic line,
    output logic break_det
);

    localparam int LIMIT = OS * BREAK_BITS;
    localparam int BCW   = $clog2(LIMIT + 1);
    localparam logic [BCW-1:0] L_LIMIT = BCW'(LIMIT);
    localparam logic [BCW-1:0] L_LAST  = BCW'(LIMIT - 1);

    logic [BCW-1:0] low_cnt;

    // Count low ticks, saturate at the limit, pulse on reaching it.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || !lin_en) begin
            low_cnt   <= '0;
            break_det <= 1'b0;
        end else begin
            break_det <= 1'b0;
            if (tick) begin
                if (line) begin
                    low_cnt <= '0;
                end else if (low_cnt != L_LIMIT) begin
                    low_cnt <= low_cnt + BCW'(1);
                    if (low_cnt == L_LAST) begin
                        break_det <= 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/uart_rx_frame.sv
// Frame engine: finds the start bit, votes each slot from three
// mid-slot samples, shifts data in LSB first, checks parity and stop,
// and emits the byte with its error flags as a one-cycle strobe.
// Assumes a synchronized line and one tick per oversampling period;
// the configuration inputs are stable while enable is high.
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int OS        = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 tick,
    input  logic                 line,
    input  logic                 data_inv,
    input  logic                 par_en,
    input  logic                 par_odd,
    input  logic                 lin_en,
    input  logic [1:0]           stop_sel,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_valid,
    output logic                 parity_err,
    output logic                 frame_err
);

    localparam int CW = $clog2(2 * OS);
    localparam int BW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [CW-1:0] L_MID      = CW'(OS / 2);
    localparam logic [CW-1:0] L_S0       = CW'(OS / 2 - 1);
    localparam logic [CW-1:0] L_HALF_S0  = CW'(OS / 4 - 1);
    localparam logic [CW-1:0] L_SLOT_END = CW'(OS - 1);
    localparam logic [BW-1:0] L_LAST_BIT = BW'(DATA_BITS - 1);

    rx_state_t             st;
    logic [CW-1:0]         cnt;
    logic [2:0]            smp;
    logic [DATA_BITS-1:0]  shreg;
    logic [BW-1:0]         bitn;
    logic                  pbit;
    logic                  any_high;

    logic [CW-1:0]         stop_last;
    logic [CW-1:0]         stop_s0;
    logic [CW-1:0]         s_base;
    logic                  vote;
    logic [DATA_BITS-1:0]  data_l;
    logic                  par_l;
    logic                  par_bad;

    // Stop-time length and first-stop sample window per stop code.
    always_comb begin
        case (stop_sel)
            STOP_HALF: begin
                stop_last = CW'(OS / 2 - 1);
                stop_s0   = L_HALF_S0;
            end
            STOP_TWO: begin
                stop_last = CW'(2 * OS - 1);
                stop_s0   = L_S0;
            end
            STOP_ONE_HALF: begin
                stop_last = CW'(OS + OS / 2 - 1);
                stop_s0   = L_S0;
            end
            default: begin
                stop_last = L_SLOT_END;
                stop_s0   = L_S0;
            end
        endcase
    end

    // Sample window base for the slot now being received.
    always_comb begin
        s_base = (st == ST_STOP) ? stop_s0 : L_S0;
    end

    // Majority vote and logical decode of the shifted data and parity.
    always_comb begin
        vote    = maj3(smp);
        data_l  = shreg ^ {DATA_BITS{data_inv}};
        par_l   = pbit ^ data_inv;
        par_bad = par_en && (par_l != ((^data_l) ^ par_odd));
    end

    // Frame sequencing, sampling and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            st         <= ST_IDLE;
            cnt        <= '0;
            smp        <= '0;
            shreg      <= '0;
            bitn       <= '0;
            pbit       <= 1'b0;
            any_high   <= 1'b0;
            rx_data    <= '0;
            rx_valid   <= 1'b0;
            parity_err <= 1'b0;
            frame_err  <= 1'b0;
        end else begin
            rx_valid   <= 1'b0;
            parity_err <= 1'b0;
            frame_err  <= 1'b0;
            if (tick) begin
                if (st != ST_IDLE && st != ST_HOLD) begin
                    cnt <= cnt + CW'(1);
                    if (cnt == s_base) begin
                        smp[0] <= line;
                    end
                    if (cnt == s_base + CW'(1)) begin
                        smp[1] <= line;
                    end
                    if (cnt == s_base + CW'(2)) begin
                        smp[2] <= line;
                    end
                end
                case (st)
                    ST_IDLE: begin
                        if (!line) begin
                            st       <= ST_START;
                            cnt      <= CW'(1);
                            any_high <= 1'b0;
                        end
                    end
                    ST_START: begin
                        if (cnt == L_MID && line) begin
                            st <= ST_IDLE;
                        end else if (cnt == L_SLOT_END) begin
                            st   <= ST_DATA;
                            cnt  <= '0;
                            bitn <= '0;
                        end
                    end
                    ST_DATA: begin
                        if (cnt == L_SLOT_END) begin
                            shreg    <= {vote, shreg[DATA_BITS-1:1]};
                            any_high <= any_high | vote;
                            cnt      <= '0;
                            if (bitn == L_LAST_BIT) begin
                                st <= par_en ? ST_PAR : ST_STOP;
                            end else begin
                                bitn <= bitn + BW'(1);
                            end
                        end
                    end
                    ST_PAR: begin
                        if (cnt == L_SLOT_END) begin
                            pbit     <= vote;
                            any_high <= any_high | vote;
                            cnt      <= '0;
                            st       <= ST_STOP;
                        end
                    end
                    ST_STOP: begin
                        if (cnt == stop_last) begin
                            cnt <= '0;
                            if (vote) begin
                                rx_valid   <= 1'b1;
                                rx_data    <= data_l;
                                parity_err <= par_bad;
                                st         <= ST_IDLE;
                            end else if (lin_en && !any_high) begin
                                st <= ST_HOLD;
                            end else begin
                                rx_valid   <= 1'b1;
                                rx_data    <= data_l;
                                parity_err <= par_bad;
                                frame_err  <= 1'b1;
                                st         <= ST_HOLD;
                            end
                        end
                    end
                    ST_HOLD: begin
                        if (line) begin
                            st <= ST_IDLE;
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/uart_line_rx.sv
// Top level: configurable serial line receiver. Holds the configuration
// while enabled, conditions the line, runs the frame engine and the
// long-break detector in parallel on the same conditioned line.
// Assumes os_tick pulses for one cycle at OS times the bit rate.
module uart_line_rx
    import uart_rx_pkg::*;
#(
    parameter int DATA_BITS   = 8,
    parameter int OS          = 16,
    parameter int BREAK_BITS  = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 os_tick,
    input  logic                 rx_pin,
    input  logic                 tx_pin,
    input  logic                 cfg_pin_inv,
    input  logic                 cfg_data_inv,
    input  logic                 cfg_swap,
    input  logic                 cfg_lin_en,
    input  logic                 cfg_par_en,
    input  logic                 cfg_par_odd,
    input  logic [1:0]           cfg_stop_sel,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_valid,
    output logic                 parity_err,
    output logic                 frame_err,
    output logic                 break_det
);

    rx_cfg_t cfg_in;
    rx_cfg_t cfg_q;
    logic    line;

    // Gather the configuration inputs into one word.
    always_comb begin
        cfg_in.pin_inv  = cfg_pin_inv;
        cfg_in.data_inv = cfg_data_inv;
        cfg_in.swap     = cfg_swap;
        cfg_in.lin_en   = cfg_lin_en;
        cfg_in.par_en   = cfg_par_en;
        cfg_in.par_odd  = cfg_par_odd;
        cfg_in.stop_sel = cfg_stop_sel;
    end

    uart_rx_cfg_hold u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    uart_rx_front #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_front (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_pin  (rx_pin),
        .tx_pin  (tx_pin),
        .swap    (cfg_q.swap),
        .pin_inv (cfg_q.pin_inv),
        .line    (line)
    );

    uart_rx_frame #(
        .DATA_BITS (DATA_BITS),
        .OS        (OS)
    ) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .tick       (os_tick),
        .line       (line),
        .data_inv   (cfg_q.data_inv),
        .par_en     (cfg_q.par_en),
        .par_odd    (cfg_q.par_odd),
        .lin_en     (cfg_q.lin_en),
        .stop_sel   (cfg_q.stop_sel),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .parity_err (parity_err),
        .frame_err  (frame_err)
    );

    uart_rx_brk #(
        .OS         (OS),
        .BREAK_BITS (BREAK_BITS)
    ) u_brk (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .lin_en    (cfg_q.lin_en),
        .tick      (os_tick),
        .line      (line),
        .break_det (break_det)
    );

endmodule

// File: rtl/uart_line_rx_chk.sv
// Checker: temporal properties of the receiver outputs and the held
// configuration. Attached to every instance of the top by bind.
module uart_line_rx_chk
    import uart_rx_pkg::*;
(
    input logic    clk,
    input logic    rst_n,
    input logic    enable,
    input logic    rx_valid,
    input logic    parity_err,
    input logic    frame_err,
    input logic    break_det,
    input rx_cfg_t cfg_q
);

    // R2: the strobe lasts one cycle.
    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R8: parity error only appears with a delivered byte.
    assert_perr_qualified_R8: assert property (@(posedge clk) disable iff (!rst_n)
        parity_err |-> rx_valid);

    // R10: framing error only appears with a delivered byte.
    assert_ferr_qualified_R10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> rx_valid);

    // R11: a break is never accompanied by a byte.
    assert_break_no_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
        break_det |-> !rx_valid);

    // R12: no break without the break mode held in the configuration.
    assert_break_needs_mode_R12: assert property (@(posedge clk) disable iff (!rst_n)
        break_det |-> cfg_q.lin_en);

    // R1: a disabled receiver stays silent.
    assert_quiet_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!rx_valid && !break_det));

    // R13: configuration is frozen while enabled.
    assert_cfg_frozen_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable)) |-> $stable(cfg_q));

endmodule

bind uart_line_rx uart_line_rx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .rx_valid   (rx_valid),
    .parity_err (parity_err),
    .frame_err  (frame_err),
    .break_det  (break_det),
    .cfg_q      (cfg_q)
);

// File: tb/sim_uart_line_rx.sv
`timescale 1ns/1ps
module sim_uart_line_rx;

    localparam int OS = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       os_tick = 1'b0;
    logic       rx_pin = 1'b1;
    logic       tx_pin = 1'b1;
    logic       cfg_pin_inv = 1'b0, cfg_data_inv = 1'b0, cfg_swap = 1'b0;
    logic       cfg_lin_en = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic [1:0] cfg_stop_sel = 2'b00;
    logic [7:0] rx_data;
    logic       rx_valid, parity_err, frame_err, break_det;

    // Bench copy of the configuration the driven frames are built for.
    logic d_pin_inv = 1'b0, d_data_inv = 1'b0, d_swap = 1'b0;
    logic d_par_en = 1'b0, d_par_odd = 1'b0;
    logic [1:0] d_stop = 2'b00;

    uart_line_rx u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .os_tick(os_tick),
        .rx_pin(rx_pin), .tx_pin(tx_pin),
        .cfg_pin_inv(cfg_pin_inv), .cfg_data_inv(cfg_data_inv),
        .cfg_swap(cfg_swap), .cfg_lin_en(cfg_lin_en),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_stop_sel(cfg_stop_sel),
        .rx_data(rx_data), .rx_valid(rx_valid), .parity_err(parity_err),
        .frame_err(frame_err), .break_det(break_det)
    );

    always #5 clk = ~clk;

    // Oversampling tick every fourth cycle, plus a tick counter.
    int ph = 0;
    int tick_no = 0;
    always @(posedge clk) begin
        ph      <= (ph == 3) ? 0 : ph + 1;
        os_tick <= (ph == 3);
        if (os_tick) tick_no <= tick_no + 1;
    end

    // Output monitor, sampled away from the active edge.
    int vcount = 0, bcount = 0, vtick = 0, btick = 0;
    logic [7:0] vdata = '0;
    logic vperr = 1'b0, vferr = 1'b0;
    always @(negedge clk) begin
        if (rx_valid) begin
            vcount = vcount + 1;
            vdata  = rx_data;
            vperr  = parity_err;
            vferr  = frame_err;
            vtick  = tick_no;
        end
        if (break_det) begin
            bcount = bcount + 1;
            btick  = tick_no;
        end
    end

    int n_chk = 0, n_fail = 0;
    int f_t0 = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    function automatic int stop_len(input logic [1:0] s);
        case (s)
            2'b01:   return OS / 2;
            2'b10:   return 2 * OS;
            2'b11:   return OS + OS / 2;
            default: return OS;
        endcase
    endfunction

    function automatic int frame_ticks(input logic pen, input logic [1:0] s);
        return OS + 8 * OS + (pen ? OS : 0) + stop_len(s);
    endfunction

    function automatic logic par_bit(input logic [7:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

    task automatic next_tick();
        int t0;
        t0 = tick_no;
        do @(negedge clk); while (tick_no == t0);
    endtask

    task automatic set_line(input logic lvl);
        logic pv;
        pv = lvl ^ d_pin_inv;
        if (d_swap) begin
            tx_pin = pv;
            rx_pin = 1'($urandom);
        end else begin
            rx_pin = pv;
            tx_pin = 1'($urandom);
        end
    endtask

    task automatic drive_samples(input logic lvl, input int n, input int glitch);
        for (int i = 0; i < n; i++) begin
            set_line((i == glitch) ? ~lvl : lvl);
            next_tick();
        end
    endtask

    task automatic idle_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            set_line(1'b1);
            next_tick();
        end
    endtask

    task automatic configure(input logic pinv, input logic dinv, input logic sw,
                             input logic lin, input logic pen, input logic podd,
                             input logic [1:0] stp);
        @(negedge clk);
        enable = 1'b0;
        cfg_pin_inv = pinv; cfg_data_inv = dinv; cfg_swap = sw;
        cfg_lin_en = lin; cfg_par_en = pen; cfg_par_odd = podd; cfg_stop_sel = stp;
        d_pin_inv = pinv; d_data_inv = dinv; d_swap = sw;
        d_par_en = pen; d_par_odd = podd; d_stop = stp;
        idle_ticks(3);
        enable = 1'b1;
        idle_ticks(3);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic corrupt,
                              input logic stop_low, input int glitch);
        vcount = 0; bcount = 0;
        next_tick();
        f_t0 = tick_no;
        drive_samples(1'b0, OS, -1);
        for (int b = 0; b < 8; b++) drive_samples(d[b] ^ d_data_inv, OS, glitch);
        if (d_par_en) drive_samples(par_bit(d, d_par_odd) ^ corrupt ^ d_data_inv, OS, -1);
        drive_samples(~stop_low, stop_len(d_stop), -1);
        idle_ticks(4);
    endtask

    task automatic expect_frame(input string req, input logic [7:0] d,
                                input logic perr, input logic ferr);
        chk(req, "strobe count", vcount, 1);
        chk(req, "data", int'(vdata), int'(d));
        chk(req, "parity_err", int'(vperr), int'(perr));
        chk(req, "frame_err", int'(vferr), int'(ferr));
        chk(req, "strobe tick", vtick - f_t0, frame_ticks(d_par_en, d_stop));
    endtask

    task automatic long_low(input int n);
        vcount = 0; bcount = 0;
        next_tick();
        f_t0 = tick_no;
        drive_samples(1'b0, n, -1);
        idle_ticks(6);
    endtask

    initial begin
        logic [7:0] d;
        logic       c;
        void'($urandom(32'h5EED_0042));
        repeat (10) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "reset rx_valid", int'(rx_valid), 0);
        chk("R1", "reset parity_err", int'(parity_err), 0);
        chk("R1", "reset frame_err", int'(frame_err), 0);
        chk("R1", "reset break_det", int'(break_det), 0);
        // R1: disabled receiver ignores a full frame
        idle_ticks(4);
        send_frame(8'hA5, 1'b0, 1'b0, -1);
        chk("R1", "disabled strobes", vcount, 0);

        // R2: basic frame
        configure(0, 0, 0, 0, 0, 0, 2'b00);
        send_frame(8'hA5, 1'b0, 1'b0, -1);
        expect_frame("R2", 8'hA5, 0, 0);

        // R3: false start recovers before mid-start
        vcount = 0;
        next_tick();
        drive_samples(1'b0, 5, -1);
        idle_ticks(40);
        chk("R3", "false start strobes", vcount, 0);
        send_frame(8'h3C, 1'b0, 1'b0, -1);
        expect_frame("R3", 8'h3C, 0, 0);

        // R4: one odd sample among 7, 8, 9
        send_frame(8'h96, 1'b0, 1'b0, 8);
        expect_frame("R4", 8'h96, 0, 0);
        send_frame(8'h69, 1'b0, 1'b0, 7);
        expect_frame("R4", 8'h69, 0, 0);
        send_frame(8'hE1, 1'b0, 1'b0, 9);
        expect_frame("R4", 8'hE1, 0, 0);

        // R5: pin inversion
        configure(1, 0, 0, 0, 0, 0, 2'b00);
        send_frame(8'h5A, 1'b0, 1'b0, -1);
        expect_frame("R5", 8'h5A, 0, 0);

        // R6: data inversion covers parity
        configure(0, 1, 0, 0, 1, 0, 2'b00);
        send_frame(8'h0F, 1'b0, 1'b0, -1);
        expect_frame("R6", 8'h0F, 0, 0);
        send_frame(8'h07, 1'b1, 1'b0, -1);
        expect_frame("R6", 8'h07, 1, 0);

        // R7: swapped pin, noise on the other
        configure(0, 0, 1, 0, 0, 0, 2'b00);
        send_frame(8'hC3, 1'b0, 1'b0, -1);
        expect_frame("R7", 8'hC3, 0, 0);

        // R8: even and odd parity, good and bad
        configure(0, 0, 0, 0, 1, 0, 2'b00);
        send_frame(8'h71, 1'b0, 1'b0, -1);
        expect_frame("R8", 8'h71, 0, 0);
        send_frame(8'h71, 1'b1, 1'b0, -1);
        expect_frame("R8", 8'h71, 1, 0);
        configure(0, 0, 0, 0, 1, 1, 2'b00);
        send_frame(8'h18, 1'b0, 1'b0, -1);
        expect_frame("R8", 8'h18, 0, 0);
        send_frame(8'h18, 1'b1, 1'b0, -1);
        expect_frame("R8", 8'h18, 1, 0);

        // R9: each stop code
        for (int s = 0; s < 4; s++) begin
            configure(0, 0, 0, 0, 0, 0, 2'(s));
            send_frame(8'h4D + 8'(s), 1'b0, 1'b0, -1);
            expect_frame("R9", 8'h4D + 8'(s), 0, 0);
        end

        // R10: low stop sample, then recovery
        configure(0, 0, 0, 0, 0, 0, 2'b00);
        send_frame(8'h81, 1'b0, 1'b1, -1);
        expect_frame("R10", 8'h81, 0, 1);
        configure(0, 0, 0, 0, 0, 0, 2'b01);
        send_frame(8'h42, 1'b0, 1'b1, -1);
        expect_frame("R10", 8'h42, 0, 1);
        send_frame(8'h24, 1'b0, 1'b0, -1);
        expect_frame("R10", 8'h24, 0, 0);

        // R11: break mode limits
        configure(0, 0, 0, 1, 0, 0, 2'b00);
        long_low(176);
        chk("R11", "break count at 176", bcount, 1);
        chk("R11", "break tick", btick - f_t0, 176);
        chk("R11", "no byte with break", vcount, 0);
        long_low(175);
        chk("R11", "break count at 175", bcount, 0);
        chk("R11", "no byte at 175", vcount, 0);
        long_low(300);
        chk("R11", "one pulse per stretch", bcount, 1);
        send_frame(8'h99, 1'b0, 1'b0, -1);
        expect_frame("R11", 8'h99, 0, 0);

        // R12: break mode off
        configure(0, 0, 0, 0, 0, 0, 2'b00);
        long_low(192);
        chk("R12", "no break", bcount, 0);
        chk("R12", "byte delivered", vcount, 1);
        chk("R12", "byte value", int'(vdata), 0);
        chk("R12", "frame_err", int'(vferr), 1);
        chk("R12", "strobe tick", vtick - f_t0, frame_ticks(1'b0, 2'b00));

        // R13: changes while enabled are ignored
        configure(0, 0, 0, 0, 0, 0, 2'b00);
        @(negedge clk);
        cfg_pin_inv = 1'b1; cfg_stop_sel = 2'b10; cfg_par_en = 1'b1; cfg_swap = 1'b1;
        send_frame(8'hB7, 1'b0, 1'b0, -1);
        expect_frame("R13", 8'hB7, 0, 0);

        // Random frames over random configurations
        for (int k = 0; k < 40; k++) begin
            configure(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                      1'($urandom), 1'($urandom), 2'($urandom));
            d = 8'($urandom);
            c = d_par_en && (($urandom % 4) == 0);
            send_frame(d, c, 1'b0, -1);
            expect_frame("R2", d, c, 0);
        end

        summary();
        $finish;
    end

endmodule